// File: doc/BRIEF.md
# Two-Stage Lockup Watchdog with Management Alerts

This block guards a system against lockups. Software programs a timeout value, enables the timer and must kick it regularly. When the count runs out the first time, the block raises a system-management interrupt request and starts a fresh period, so software gets a chance to recover. If that second period also runs out with no kick, the block drives a system reset pulse of fixed length. When the pulse ends, every register returns to its reset value and the timer is left disabled.

Three management events arrive as raw inputs:
- a case-open switch (active low);
- a thermal alarm;
- a flag saying the processor failed to boot.

Each input passes through a two-flop synchronizer and an edge detector. The edge sets a sticky status bit, which software clears by writing 1. An event can be routed to an interrupt output. An event can also start a fixed eight-byte alert message, which is sent one byte per valid/ready handshake on a byte-serial output. Events that arrive while a message is in flight merge into a single pending request.

Software reaches the block through a write-only port with a 2-bit address:

| Address | Name | Effect of a write |
|---|---|---|
| 0 | CTRL | Loads the control bits listed below |
| 1 | RELOAD | Loads the timeout value |
| 2 | KICK | Any data; restarts the count |
| 3 | CLEAR | Write-1-to-clear of the status bits |

The CTRL bits are:

| Bit(s) | Meaning |
|---|---|
| 0 | Timer enable |
| 1 | Intrusion routing: 0 selects the SMI output, 1 selects the TCO output |
| 4:2 | Interrupt enable, one bit per event |
| 7:5 | Alert enable, one bit per event |

The event index, used for the status bits and for both enable fields, is 0 for intrusion, 1 for thermal and 2 for no-boot.

Top module: `lockup_watchdog`

## Requirements
- R1: With reload value N, the first timer expiry happens N+1 clock cycles after the write that enables the timer or kicks it. A kick made before expiry restarts the full N+1 cycle period.
- R2: The first expiry sets `smiReq` and reloads the count. A kick (any write to address 2) clears this first-stage flag.
- R3: A second expiry with no kick since the first asserts `sysReset` for exactly 16 consecutive cycles.
- R4: When `sysReset` ends, the block is back in its reset state: timer disabled, reload value back to its default, status bits cleared, interrupts low and the alert output idle.
- R5: While CTRL bit 0 is 0, the count does not run, and neither `smiReq` from the timer nor `sysReset` is produced. Clearing bit 0 also clears the first-stage flag.
- R6: A falling edge on `intrudeN` sets `eventStatus[0]`, a rising edge on `thermalAlarm` sets `eventStatus[1]` and a rising edge on `noBootFlag` sets `eventStatus[2]`. Each bit is visible within three cycles and stays set. An input held at its active level does not set its bit again.
- R7: Writing address 2'd3 clears exactly the status bits written as 1 in `wrData[2:0]` and leaves the others unchanged.
- R8: A set, enabled intrusion status drives `smiReq` when CTRL bit 1 is 0 and `tcoIrq` when it is 1. A set, enabled thermal or no-boot status drives `tcoIrq`. A status bit whose enable is 0 drives neither output.
- R9: An event edge whose alert enable is set starts the message 0x57,0x44,0x4F,0x47,0x45,0x56,0x4E,0x54, sent in that order, one byte per cycle in which `alertValid` and `alertReady` are both high. While `alertReady` is low, `alertValid` and `alertData` hold steady. After the last byte, `alertValid` drops.
- R10: Any number of alert-enabled events arriving during a message cause exactly one more complete message, which starts right after the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address (0 CTRL, 1 RELOAD, 2 KICK, 3 CLEAR) |
| wrData | input | COUNT_W | Write data |
| intrudeN | input | 1 | Case-open switch, active low, asynchronous |
| thermalAlarm | input | 1 | Thermal alarm, active high, asynchronous |
| noBootFlag | input | 1 | Processor-failed-to-boot flag, active high, asynchronous |
| alertReady | input | 1 | Sink accepts the current alert byte |
| smiReq | output | 1 | System-management interrupt request |
| tcoIrq | output | 1 | Management (TCO) interrupt request |
| sysReset | output | 1 | System reset request, held 16 cycles |
| eventStatus | output | 3 | Sticky event status (bit 0 intrusion, 1 thermal, 2 no-boot) |
| alertValid | output | 1 | Alert byte valid |
| alertData | output | 8 | Alert byte |

## Verification
The timer is driven with three kinds of stimulus:
- An undisturbed run. It pins the exact expiry cycle and the 16-cycle reset length.
- A run kicked part way through. It separates a true restart from a count that merely continues.
- A run disabled part way through. It shows whether the enable really gates expiry and clears the first stage.

Events are applied one at a time and as held levels, which tells true edge detection apart from level sensing. Alert traffic is tried with a stalled sink, with an unstalled sink, and with one or two events landing mid-message. Together these show whether the bytes hold steady, whether they go out in order, and whether repeated events collapse into a single follow-up message.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  localparam int NUM_EVENTS = 3;
  localparam int EV_INTRUDE = 0;
  localparam int EV_THERMAL = 1;
  localparam int EV_NOBOOT  = 2;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_RELOAD = 2'd1;
  localparam logic [1:0] ADDR_KICK   = 2'd2;
  localparam logic [1:0] ADDR_CLEAR  = 2'd3;

  localparam int CTRL_ENABLE      = 0;
  localparam int CTRL_ROUTE_TCO   = 1;
  localparam int CTRL_INTEN_LSB   = 2;
  localparam int CTRL_ALERTEN_LSB = 5;
  localparam int CTRL_W           = CTRL_ALERTEN_LSB + NUM_EVENTS;

  localparam int MSG_BYTES = 8;
  localparam int MSG_IDX_W = $clog2(MSG_BYTES);
  // fixed alert text, first byte in the top bits
  localparam logic [8*MSG_BYTES-1:0] ALERT_MSG = 64'h57444F4745564E54;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCount;
    logic decCount;
    logic restoreDefaults;
    logic blockWrites;
    logic byteRestart;
    logic byteNext;
  } wdgStrobe_t;

  typedef enum logic {ALERT_IDLE, ALERT_SEND} alertState_t;

  function automatic logic [7:0] alertByte(input logic [MSG_IDX_W-1:0] idx);
    return ALERT_MSG[(8*MSG_BYTES - 1 - 8*int'(idx)) -: 8];
  endfunction

endpackage

// File: rtl/wdg_event_sync.sv
module wdg_event_sync #(
  parameter int NUM = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] rawActive,
  output logic [NUM-1:0] edgeStb
);

  for (genvar g = 0; g < NUM; g++) begin : g_chan
    logic meta, stable, prevStable;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta       <= 1'b0;
        stable     <= 1'b0;
        prevStable <= 1'b0;
      end else begin
        meta       <= rawActive[g];
        stable     <= meta;
        prevStable <= stable;
      end
    end
    assign edgeStb[g] = stable & ~prevStable;
  end

endmodule

// File: rtl/wdg_datapath.sv
module wdg_datapath
  import wdg_pkg::*;
#(
  parameter int          COUNT_W        = 16,
  parameter logic [15:0] DEFAULT_RELOAD = 16'd1000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrEn,
  input  logic [1:0]            wrAddr,
  input  logic [COUNT_W-1:0]    wrData,
  input  logic [NUM_EVENTS-1:0] eventEdge,
  input  wdgStrobe_t            strobe,
  output logic                  countZero,
  output logic                  kickStb,
  output logic                  enRise,
  output logic                  enFall,
  output logic                  timerOn,
  output logic                  routeTco,
  output logic [NUM_EVENTS-1:0] intEn,
  output logic [NUM_EVENTS-1:0] alertEn,
  output logic [NUM_EVENTS-1:0] eventStatus,
  output logic [7:0]            alertData,
  output logic                  lastByte
);

  localparam logic [COUNT_W-1:0] RELOAD_INIT = COUNT_W'(DEFAULT_RELOAD);

  logic [CTRL_W-1:0]     ctrlReg;
  logic [COUNT_W-1:0]    reloadReg;
  logic [COUNT_W-1:0]    count;
  logic [MSG_IDX_W-1:0]  byteIdx;
  logic                  wrOk, wrCtrl, wrReload, wrClear;
  logic [NUM_EVENTS-1:0] clearMask;

  assign wrOk     = wrEn & ~strobe.blockWrites;
  assign wrCtrl   = wrOk & (wrAddr == ADDR_CTRL);
  assign wrReload = wrOk & (wrAddr == ADDR_RELOAD);
  assign kickStb  = wrOk & (wrAddr == ADDR_KICK);
  assign wrClear  = wrOk & (wrAddr == ADDR_CLEAR);
  assign enRise   = wrCtrl &  wrData[CTRL_ENABLE] & ~ctrlReg[CTRL_ENABLE];
  assign enFall   = wrCtrl & ~wrData[CTRL_ENABLE] &  ctrlReg[CTRL_ENABLE];
  assign clearMask = wrClear ? wrData[NUM_EVENTS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg     <= '0;
      reloadReg   <= RELOAD_INIT;
      count       <= RELOAD_INIT;
      eventStatus <= '0;
      byteIdx     <= '0;
    end else if (strobe.restoreDefaults) begin
      ctrlReg     <= '0;
      reloadReg   <= RELOAD_INIT;
      count       <= RELOAD_INIT;
      eventStatus <= '0;
      byteIdx     <= '0;
    end else begin
      if (wrCtrl)   ctrlReg   <= wrData[CTRL_W-1:0];
      if (wrReload) reloadReg <= wrData;
      if (strobe.loadCount)     count <= reloadReg;
      else if (strobe.decCount) count <= count - 1'b1;
      eventStatus <= (eventStatus & ~clearMask) | eventEdge;
      if (strobe.byteRestart)   byteIdx <= '0;
      else if (strobe.byteNext) byteIdx <= byteIdx + 1'b1;
    end
  end

  assign countZero = (count == '0);
  assign timerOn   = ctrlReg[CTRL_ENABLE];
  assign routeTco  = ctrlReg[CTRL_ROUTE_TCO];
  assign intEn     = ctrlReg[CTRL_INTEN_LSB +: NUM_EVENTS];
  assign alertEn   = ctrlReg[CTRL_ALERTEN_LSB +: NUM_EVENTS];
  assign alertData = alertByte(byteIdx);
  assign lastByte  = (byteIdx == MSG_IDX_W'(MSG_BYTES - 1));

endmodule

// File: rtl/wdg_control.sv
module wdg_control
  import wdg_pkg::*;
#(
  parameter int RESET_HOLD = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       timerOn,
  input  logic       countZero,
  input  logic       kickStb,
  input  logic       enRise,
  input  logic       enFall,
  input  logic       alertReq,
  input  logic       alertReady,
  input  logic       lastByte,
  output wdgStrobe_t strobe,
  output logic       firstExpired,
  output logic       sysReset,
  output logic       alertValid
);

  localparam int HOLD_W = $clog2(RESET_HOLD + 1);
  localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(RESET_HOLD - 1);

  logic              holdActive;
  logic [HOLD_W-1:0] holdCnt;
  logic              expiry, holdDone, handshake, msgDone, msgAgain;
  alertState_t       alertState;
  logic              pending;

  assign expiry    = timerOn & countZero & ~holdActive & ~kickStb & ~enFall;
  assign holdDone  = holdActive & (holdCnt == HOLD_LAST);
  assign handshake = (alertState == ALERT_SEND) & alertReady;
  assign msgDone   = handshake & lastByte;
  assign msgAgain  = msgDone & (pending | alertReq);

  always_comb begin
    strobe                 = '0;
    strobe.loadCount       = ~holdActive & (kickStb | enRise | (expiry & ~firstExpired));
    strobe.decCount        = timerOn & ~countZero & ~holdActive;
    strobe.restoreDefaults = holdDone;
    strobe.blockWrites     = holdActive;
    strobe.byteRestart     = ((alertState == ALERT_IDLE) & alertReq) | msgAgain;
    strobe.byteNext        = handshake & ~lastByte;
  end

  // timer stages and reset hold
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      firstExpired <= 1'b0;
      holdActive   <= 1'b0;
      holdCnt      <= '0;
    end else if (holdActive) begin
      if (holdDone) begin
        holdActive   <= 1'b0;
        holdCnt      <= '0;
        firstExpired <= 1'b0;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end else if (kickStb | enFall) begin
      firstExpired <= 1'b0;
    end else if (expiry) begin
      if (firstExpired) begin
        holdActive <= 1'b1;
        holdCnt    <= '0;
      end else begin
        firstExpired <= 1'b1;
      end
    end
  end

  // alert sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alertState <= ALERT_IDLE;
      pending    <= 1'b0;
    end else if (holdDone) begin
      alertState <= ALERT_IDLE;
      pending    <= 1'b0;
    end else begin
      case (alertState)
        ALERT_IDLE: if (alertReq) alertState <= ALERT_SEND;
        ALERT_SEND: begin
          if (msgDone) begin
            pending <= 1'b0;
            if (!msgAgain) alertState <= ALERT_IDLE;
          end else if (alertReq) begin
            pending <= 1'b1;
          end
        end
        default: alertState <= ALERT_IDLE;
      endcase
    end
  end

  assign sysReset   = holdActive;
  assign alertValid = (alertState == ALERT_SEND);

endmodule

// File: rtl/lockup_watchdog.sv
module lockup_watchdog
  import wdg_pkg::*;
#(
  parameter int          COUNT_W        = 16,
  parameter logic [15:0] DEFAULT_RELOAD = 16'd1000,
  parameter int          RESET_HOLD     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrEn,
  input  logic [1:0]            wrAddr,
  input  logic [COUNT_W-1:0]    wrData,
  input  logic                  intrudeN,
  input  logic                  thermalAlarm,
  input  logic                  noBootFlag,
  input  logic                  alertReady,
  output logic                  smiReq,
  output logic                  tcoIrq,
  output logic                  sysReset,
  output logic [NUM_EVENTS-1:0] eventStatus,
  output logic                  alertValid,
  output logic [7:0]            alertData
);

  wdgStrobe_t            strobe;
  logic [NUM_EVENTS-1:0] rawActive, eventEdge, intEn, alertEn, tcoMask;
  logic countZero, kickStb, enRise, enFall, timerOn, routeTco;
  logic lastByte, firstExpired, alertReq, intrusionSmi;

  assign rawActive[EV_INTRUDE] = ~intrudeN;
  assign rawActive[EV_THERMAL] = thermalAlarm;
  assign rawActive[EV_NOBOOT]  = noBootFlag;

  wdg_event_sync #(.NUM(NUM_EVENTS)) u_sync (
    .clk(clk), .rst_n(rst_n), .rawActive(rawActive), .edgeStb(eventEdge)
  );

  wdg_datapath #(.COUNT_W(COUNT_W), .DEFAULT_RELOAD(DEFAULT_RELOAD)) u_dp (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .eventEdge(eventEdge), .strobe(strobe), .countZero(countZero),
    .kickStb(kickStb), .enRise(enRise), .enFall(enFall), .timerOn(timerOn),
    .routeTco(routeTco), .intEn(intEn), .alertEn(alertEn),
    .eventStatus(eventStatus), .alertData(alertData), .lastByte(lastByte)
  );

  assign alertReq = |(eventEdge & alertEn);

  wdg_control #(.RESET_HOLD(RESET_HOLD)) u_ctl (
    .clk(clk), .rst_n(rst_n), .timerOn(timerOn), .countZero(countZero),
    .kickStb(kickStb), .enRise(enRise), .enFall(enFall), .alertReq(alertReq),
    .alertReady(alertReady), .lastByte(lastByte), .strobe(strobe),
    .firstExpired(firstExpired), .sysReset(sysReset), .alertValid(alertValid)
  );

  always_comb begin
    tcoMask             = '1;
    tcoMask[EV_INTRUDE] = routeTco;
  end
  assign intrusionSmi = eventStatus[EV_INTRUDE] & intEn[EV_INTRUDE] & ~routeTco;
  assign smiReq       = firstExpired | intrusionSmi;
  assign tcoIrq       = |(eventStatus & intEn & tcoMask);

endmodule

// File: rtl/wdg_checker.sv
module wdg_checker #(
  parameter int RESET_HOLD = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wrEn,
  input logic [1:0] wrAddr,
  input logic       timerOn,
  input logic       smiReq,
  input logic       sysReset,
  input logic [2:0] eventStatus,
  input logic       alertValid,
  input logic       alertReady,
  input logic [7:0] alertData
);

  localparam int RUN_W = $clog2(RESET_HOLD + 2);
  logic [RUN_W-1:0] runLen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        runLen <= '0;
    else if (sysReset) runLen <= runLen + 1'b1;
    else               runLen <= '0;
  end

  assert_reset_not_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sysReset |-> (runLen < RUN_W'(RESET_HOLD)));

  assert_reset_full_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sysReset) |-> (runLen == RUN_W'(RESET_HOLD)));

  assert_reset_after_smi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysReset) |-> $past(smiReq));

  assert_reset_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sysReset) |-> $past(timerOn));

  assert_defaults_after_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sysReset) |-> (!timerOn && eventStatus == 3'b000 && !alertValid && !smiReq));

  assert_status_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~eventStatus & $past(eventStatus)) != 3'b000) |->
      ($past(wrEn && wrAddr == 2'd3) || $past(sysReset)));

  assert_alert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alertValid && !alertReady && !sysReset) |=> (alertValid && $stable(alertData)));

endmodule

bind lockup_watchdog wdg_checker #(.RESET_HOLD(RESET_HOLD)) u_wdg_checker (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .timerOn(timerOn),
  .smiReq(smiReq), .sysReset(sysReset), .eventStatus(eventStatus),
  .alertValid(alertValid), .alertReady(alertReady), .alertData(alertData)
);

// File: tb/test_lockup_watchdog.sv
`timescale 1ns/1ps
module test_lockup_watchdog;

  localparam int COUNT_W = 16;
  localparam logic [63:0] EXPECT_MSG = 64'h57444F4745564E54;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [COUNT_W-1:0] wrData = '0;
  logic intrudeN = 1'b1, thermalAlarm = 1'b0, noBootFlag = 1'b0, alertReady = 1'b0;
  logic smiReq, tcoIrq, sysReset, alertValid;
  logic [2:0] eventStatus;
  logic [7:0] alertData;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  lockup_watchdog #(.COUNT_W(COUNT_W)) i_lockup_watchdog (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .intrudeN(intrudeN), .thermalAlarm(thermalAlarm), .noBootFlag(noBootFlag),
    .alertReady(alertReady), .smiReq(smiReq), .tcoIrq(tcoIrq), .sysReset(sysReset),
    .eventStatus(eventStatus), .alertValid(alertValid), .alertData(alertData)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [COUNT_W-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    step(1);
    wrEn = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] msgByte(input int k);
    return EXPECT_MSG[63 - 8*k -: 8];
  endfunction

  task automatic waitValid(input string req);
    int n = 0;
    while (!alertValid && n < 20) begin step(1); n++; end
    chk(req, alertValid, 1);
  endtask

  task automatic t_reset;
    chk("R4 reset smi", smiReq, 0);
    chk("R4 reset tco", tcoIrq, 0);
    chk("R4 reset sysReset", sysReset, 0);
    chk("R4 reset status", eventStatus, 0);
    chk("R4 reset alert", alertValid, 0);
  endtask

  task automatic t_first_expiry;
    wr(2'd1, 16'd10);
    wr(2'd0, 16'h0001);
    step(10);
    chk("R1 no expiry before N+1", smiReq, 0);
    step(1);
    chk("R2 first expiry smi", smiReq, 1);
    wr(2'd2, 16'h0);
    chk("R2 kick clears smi", smiReq, 0);
    step(10);
    chk("R1 after kick early", smiReq, 0);
    step(1);
    chk("R1 after kick expiry", smiReq, 1);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_kick_restart;
    wr(2'd0, 16'h0001);
    step(6);
    wr(2'd2, 16'h0);
    step(10);
    chk("R1 kick restarts period", smiReq, 0);
    step(1);
    chk("R1 expiry after restart", smiReq, 1);
    wr(2'd0, 16'h0000);
    chk("R5 disable clears stage", smiReq, 0);
  endtask

  task automatic t_disabled;
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h0001);
    step(3);
    wr(2'd0, 16'h0000);
    step(30);
    chk("R5 disabled no smi", smiReq, 0);
    chk("R5 disabled no reset", sysReset, 0);
  endtask

  task automatic t_second_expiry;
    int cnt = 0;
    wr(2'd1, 16'd10);
    wr(2'd0, 16'h0001);
    thermalAlarm = 1'b1;
    step(10);
    chk("R6 thermal latched", eventStatus, 3'b010);
    step(1);
    chk("R2 stage one", smiReq, 1);
    chk("R3 no reset at first", sysReset, 0);
    step(10);
    chk("R3 no reset early", sysReset, 0);
    step(1);
    chk("R3 reset asserted", sysReset, 1);
    for (int i = 0; i < 20; i++) begin
      if (sysReset) cnt++;
      step(1);
    end
    chk("R3 reset length", cnt, 16);
    chk("R4 status cleared", eventStatus, 0);
    chk("R4 smi cleared", smiReq, 0);
    chk("R4 alert idle", alertValid, 0);
    step(40);
    chk("R4 timer disabled", {sysReset, smiReq}, 0);
    wr(2'd0, 16'h0001);
    step(11);
    chk("R4 reload back to default", smiReq, 0);
    wr(2'd0, 16'h0000);
    thermalAlarm = 1'b0;
    step(4);
  endtask

  task automatic t_events;
    intrudeN = 1'b0;
    step(3);
    chk("R6 intrusion latched", eventStatus, 3'b001);
    noBootFlag = 1'b1;
    step(3);
    chk("R6 noboot latched", eventStatus, 3'b101);
    wr(2'd3, 16'h0001);
    step(6);
    chk("R6 held level no re-set", eventStatus, 3'b100);
    thermalAlarm = 1'b1;
    step(3);
    chk("R6 thermal edge", eventStatus, 3'b110);
    intrudeN = 1'b1; step(3); intrudeN = 1'b0; step(3);
    chk("R6 second intrusion edge", eventStatus, 3'b111);
  endtask

  task automatic t_w1c;
    wr(2'd3, 16'h0002);
    chk("R7 clear one bit", eventStatus, 3'b101);
    wr(2'd3, 16'h0005);
    chk("R7 clear rest", eventStatus, 3'b000);
  endtask

  task automatic t_route;
    intrudeN = 1'b1; thermalAlarm = 1'b0; noBootFlag = 1'b0;
    step(4);
    wr(2'd0, 16'h0004);
    intrudeN = 1'b0;
    step(3);
    chk("R8 intrusion to smi", {smiReq, tcoIrq}, 2'b10);
    wr(2'd0, 16'h0006);
    chk("R8 intrusion to tco", {smiReq, tcoIrq}, 2'b01);
    wr(2'd0, 16'h0000);
    chk("R8 masked", {smiReq, tcoIrq}, 2'b00);
    wr(2'd3, 16'h0007);
    wr(2'd0, 16'h0008);
    thermalAlarm = 1'b1;
    step(3);
    chk("R8 thermal to tco", {smiReq, tcoIrq}, 2'b01);
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'h0007);
    intrudeN = 1'b1; thermalAlarm = 1'b0;
    step(4);
  endtask

  task automatic recvMsg(input string req);
    alertReady = 1'b1;
    for (int k = 0; k < 8; k++) begin
      chk(req, {alertValid, alertData}, {1'b1, msgByte(k)});
      step(1);
    end
  endtask

  task automatic t_alert;
    wr(2'd0, 16'h0040);
    alertReady = 1'b0;
    thermalAlarm = 1'b1;
    waitValid("R9 alert starts");
    chk("R9 first byte", alertData, 8'h57);
    step(3);
    chk("R9 stall holds", {alertValid, alertData}, {1'b1, 8'h57});
    recvMsg("R9 message byte");
    chk("R9 ends", alertValid, 0);
    alertReady = 1'b0;
    thermalAlarm = 1'b0;
    step(4);
  endtask

  task automatic t_pending;
    wr(2'd0, 16'h00E0);
    wr(2'd3, 16'h0007);
    thermalAlarm = 1'b1;
    waitValid("R10 alert starts");
    alertReady = 1'b1;
    for (int k = 0; k < 8; k++) begin
      if (k == 1) noBootFlag = 1'b1;
      if (k == 3) intrudeN = 1'b0;
      chk("R10 first message", {alertValid, alertData}, {1'b1, msgByte(k)});
      step(1);
    end
    recvMsg("R10 queued message");
    chk("R10 only one extra", alertValid, 0);
    step(10);
    chk("R10 stays idle", alertValid, 0);
    alertReady = 1'b0;
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_first_expiry();
    t_kick_restart();
    t_disabled();
    t_second_expiry();
    t_events();
    t_w1c();
    t_route();
    t_alert();
    t_pending();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule